// File: doc/BRIEF.md
# Chained-Operand Accumulator ALU

This execution unit runs a stream of decoded instructions in which the arithmetic and logic operations carry no operand fields. Two operand slots, A and B, feed the ALU. Separate load instructions fill a slot, either from an immediate carried by the instruction or from one of sixteen 40-bit scratch registers. An ALU instruction combines the slots into a 40-bit result. That result is also written back into slot A, so the next operation picks it up as its first operand without any register traffic.

The register file is optional storage. A move instruction copies the current result into a named register. Each such copy also appears for one cycle on a registered write port, so the surrounding pipeline can observe or mirror it. The unit takes one instruction per clock. Its ready output is always high.

Top module: `chain_alu_unit`

## Requirements
- R1: After synchronous reset, the result is zero, the write port strobe is low, both operand slots are zero and all sixteen registers read as zero.
- R2: Opcode 1 loads the immediate into slot A. Opcode 2 loads the immediate into slot B. Neither opcode changes the result.
- R3: Opcode 5 sets the result to A+B and opcode 6 sets it to A-B, both modulo 2^40.
- R4: Opcode 7 sets the result to A AND B, opcode 8 to A OR B and opcode 9 to A XOR B, bitwise.
- R5: Opcode 10 sets the result to the bitwise inverse of A and ignores slot B.
- R6: Every ALU opcode (5 to 10) also places its new result into slot A, so the next ALU opcode uses it as its first operand.
- R7: Slot B keeps its value until the next opcode 2 or opcode 4, so successive binary operations reuse it.
- R8: Opcode 11 copies the result into the register named by the 4-bit index. In the following cycle the write strobe is high for exactly one cycle, with that index and that result on the write port.
- R9: Opcode 3 loads slot A from the register named by the 4-bit index, and opcode 4 loads slot B from it. A register written by opcode 11 holds the new value for the very next instruction.
- R10: An instruction presented with valid low has no effect. Opcode 0 and opcodes 12 to 15 also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted (always high) |
| in_opcode | input | 4 | Operation code |
| in_idx | input | 4 | Register index |
| in_imm | input | 40 | Immediate value |
| result | output | 40 | Current ALU result |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register written |
| wr_data | output | 40 | Value written |

## Verification
A corrupted result shows on the result output at the same edge that commits the instruction. A wrong slot A or slot B is visible only after the next ALU opcode has used it, so the bench runs many operations back to back. A wrong register value stays hidden until that register is loaded and passes through an ALU operation, which can be many cycles later. For that reason the bench reads every register it writes back through a load followed by an OR with zero, and a long pseudo-random stream with a cycle-by-cycle model catches latent errors as soon as they reach the result or the write port.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;

    localparam int WORD_W  = 40;
    localparam int REG_CNT = 16;
    localparam int IDX_W   = $clog2(REG_CNT);
    localparam int OPC_W   = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OPC_W-1:0] {
        OPC_NOP  = 4'd0,
        OPC_LDIA = 4'd1,
        OPC_LDIB = 4'd2,
        OPC_LDRA = 4'd3,
        OPC_LDRB = 4'd4,
        OPC_ADD  = 4'd5,
        OPC_SUB  = 4'd6,
        OPC_AND  = 4'd7,
        OPC_OR   = 4'd8,
        OPC_XOR  = 4'd9,
        OPC_NOT  = 4'd10,
        OPC_MOVR = 4'd11
    } opcode_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_NOT
    } alu_fn_e;

    typedef struct packed {
        logic    load_a;
        logic    load_b;
        logic    from_reg;
        logic    fire;
        alu_fn_e fn;
        logic    store;
    } ctrl_t;

endpackage

// File: rtl/chain_alu_decode.sv
module chain_alu_decode
    import chain_alu_pkg::*;
(
    input  logic             take,
    input  logic [OPC_W-1:0] opc,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl = '0;
        if (take) begin
            case (opcode_e'(opc))
                OPC_LDIA: ctrl.load_a = 1'b1;
                OPC_LDIB: ctrl.load_b = 1'b1;
                OPC_LDRA: begin
                    ctrl.load_a   = 1'b1;
                    ctrl.from_reg = 1'b1;
                end
                OPC_LDRB: begin
                    ctrl.load_b   = 1'b1;
                    ctrl.from_reg = 1'b1;
                end
                OPC_ADD: begin ctrl.fire = 1'b1; ctrl.fn = FN_ADD; end
                OPC_SUB: begin ctrl.fire = 1'b1; ctrl.fn = FN_SUB; end
                OPC_AND: begin ctrl.fire = 1'b1; ctrl.fn = FN_AND; end
                OPC_OR:  begin ctrl.fire = 1'b1; ctrl.fn = FN_OR;  end
                OPC_XOR: begin ctrl.fire = 1'b1; ctrl.fn = FN_XOR; end
                OPC_NOT: begin ctrl.fire = 1'b1; ctrl.fn = FN_NOT; end
                OPC_MOVR: ctrl.store = 1'b1;
                default: ctrl = '0;
            endcase
        end
    end

    always_comb begin
        if (take === 1'b1)
            AST_ONE_ACTION: assert ($countones({ctrl.load_a, ctrl.load_b, ctrl.fire, ctrl.store}) <= 1); // R10
    end

endmodule

// File: rtl/chain_alu_core.sv
module chain_alu_core
    import chain_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_NOT:  y = ~a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/chain_alu_regfile.sv
module chain_alu_regfile #(
    parameter int W     = 40,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    AST_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R8

endmodule

// File: rtl/chain_alu_unit.sv
module chain_alu_unit
    import chain_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [WORD_W-1:0] in_imm,
    output logic [WORD_W-1:0] result,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data
);

    ctrl_t ctrl;
    word_t slot_a, slot_b, res_q, alu_y, reg_rd, load_val;

    assign in_ready = 1'b1;

    chain_alu_decode u_dec (
        .take (in_valid & in_ready),
        .opc  (in_opcode),
        .ctrl (ctrl)
    );

    chain_alu_core #(.W(WORD_W)) u_core (
        .fn (ctrl.fn),
        .a  (slot_a),
        .b  (slot_b),
        .y  (alu_y)
    );

    chain_alu_regfile #(.W(WORD_W), .DEPTH(REG_CNT)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.store),
        .waddr (in_idx),
        .wdata (res_q),
        .raddr (in_idx),
        .rdata (reg_rd)
    );

    assign load_val = ctrl.from_reg ? reg_rd : in_imm;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_a  <= '0;
            slot_b  <= '0;
            res_q   <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ctrl.load_a) slot_a <= load_val;
            if (ctrl.load_b) slot_b <= load_val;
            if (ctrl.fire) begin
                res_q  <= alu_y;
                slot_a <= alu_y;
            end
            if (ctrl.store) begin
                wr_en   <= 1'b1;
                wr_idx  <= in_idx;
                wr_data <= res_q;
            end
        end
    end

    assign result = res_q;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl.fire |=> $stable(res_q)); // R2
    AST_CHAIN_A: assert property (@(posedge clk) disable iff (rst)
        ctrl.fire |=> (slot_a == res_q)); // R6
    AST_B_KEEP: assert property (@(posedge clk) disable iff (rst)
        !ctrl.load_b |=> $stable(slot_b)); // R7
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        ctrl.store |=> (wr_en && wr_data == $past(res_q) && wr_idx == $past(in_idx))); // R8
    AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_opcode == 4'd11) |=> !wr_en); // R10

endmodule

// File: tb/sim_chain_alu_unit.sv
module sim_chain_alu_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_opcode = '0;
    logic [3:0]  in_idx = '0;
    logic [39:0] in_imm = '0;
    logic [39:0] result;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [39:0] wr_data;

    always #5 clk = ~clk;

    chain_alu_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_idx(in_idx), .in_imm(in_imm),
        .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [39:0] m_a, m_b, m_res;
    logic [39:0] m_regs [16];
    logic        m_wr;
    logic [3:0]  m_widx;
    logic [39:0] m_wdata;
    logic [31:0] lfsr = 32'h1BADF00D;

    task automatic chk(string tag, bit ok, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(bit v, logic [3:0] op, logic [3:0] idx, logic [39:0] imm);
        m_wr = 1'b0;
        if (v) begin
            case (op)
                4'd1:  m_a = imm;
                4'd2:  m_b = imm;
                4'd3:  m_a = m_regs[idx];
                4'd4:  m_b = m_regs[idx];
                4'd5:  begin m_res = m_a + m_b; m_a = m_res; end
                4'd6:  begin m_res = m_a - m_b; m_a = m_res; end
                4'd7:  begin m_res = m_a & m_b; m_a = m_res; end
                4'd8:  begin m_res = m_a | m_b; m_a = m_res; end
                4'd9:  begin m_res = m_a ^ m_b; m_a = m_res; end
                4'd10: begin m_res = ~m_a; m_a = m_res; end
                4'd11: begin
                    m_wr = 1'b1; m_widx = idx; m_wdata = m_res;
                    m_regs[idx] = m_res;
                end
                default: ;
            endcase
        end
    endtask

    task automatic step(string tag, bit v, logic [3:0] op, logic [3:0] idx, logic [39:0] imm);
        in_valid = v; in_opcode = op; in_idx = idx; in_imm = imm;
        model(v, op, idx, imm);
        @(negedge clk);
        chk({tag, " result"}, result == m_res, result, m_res);
        chk({tag, " wr_en"}, wr_en == m_wr, {39'd0, wr_en}, {39'd0, m_wr});
        if (m_wr) begin
            chk({tag, " wr_idx"}, wr_idx == m_widx, {36'd0, wr_idx}, {36'd0, m_widx});
            chk({tag, " wr_data"}, wr_data == m_wdata, wr_data, m_wdata);
        end
    endtask

    // Bring a register out to the result port: load A from it, B=0, OR.
    task automatic peek(string tag, logic [3:0] r);
        step(tag, 1, 4'd3, r, 40'd0);
        step(tag, 1, 4'd2, 4'd0, 40'd0);
        step(tag, 1, 4'd8, 4'd0, 40'd0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_a = '0; m_b = '0; m_res = '0; m_wr = 0; m_widx = '0; m_wdata = '0;
        for (int i = 0; i < 16; i++) m_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 result", result == 40'd0, result, 40'd0);
        chk("R1 wr_en", wr_en == 1'b0, {39'd0, wr_en}, 40'd0);
        chk("R1 ready", in_ready == 1'b1, {39'd0, in_ready}, 40'd1);
        step("R1 slotA", 1, 4'd9, 4'd0, 40'd0);
        peek("R1 reg5", 4'd5);
        // R2: loads leave result alone
        step("R2 ldA", 1, 4'd1, 4'd0, 40'hFF_0000_1234);
        step("R2 ldB", 1, 4'd2, 4'd0, 40'h01_0000_0001);
        // R3 add with carry out of bit 39
        step("R3 add", 1, 4'd5, 4'd0, 40'd0);
        // R5/R6: NOT of the sum, B ignored
        step("R5 not", 1, 4'd10, 4'd0, 40'd0);
        step("R3 R6 sub chain", 1, 4'd6, 4'd0, 40'd0);
        step("R3 ldA0", 1, 4'd1, 4'd0, 40'd0);
        step("R3 ldB1", 1, 4'd2, 4'd0, 40'd1);
        step("R3 sub wrap", 1, 4'd6, 4'd0, 40'd0);
        // R4 logic ops
        step("R4 ldA", 1, 4'd1, 4'd0, 40'hF0F0_F0F0_F0);
        step("R4 ldB", 1, 4'd2, 4'd0, 40'hFF00_FF00_FF);
        step("R4 and", 1, 4'd7, 4'd0, 40'd0);
        step("R4 or", 1, 4'd8, 4'd0, 40'd0);
        step("R4 xor", 1, 4'd9, 4'd0, 40'd0);
        // R7 B reused across adds
        step("R7 add1", 1, 4'd5, 4'd0, 40'd0);
        step("R7 add2", 1, 4'd5, 4'd0, 40'd0);
        // R8 move to register, R9 read back
        step("R8 movr", 1, 4'd11, 4'd3, 40'd0);
        step("R8 quiet", 1, 4'd0, 4'd0, 40'd0);
        step("R8 movr15", 1, 4'd11, 4'd15, 40'd0);
        step("R9 ldB r3", 1, 4'd4, 4'd3, 40'd0);
        step("R9 ldA r15", 1, 4'd3, 4'd15, 40'd0);
        step("R9 xor", 1, 4'd9, 4'd0, 40'd0);
        step("R9 movr7", 1, 4'd11, 4'd7, 40'd0);
        peek("R9 reg7", 4'd7);
        // R10: invalid and undefined opcodes
        step("R10 invalid add", 0, 4'd5, 4'd0, 40'd0);
        step("R10 invalid movr", 0, 4'd11, 4'd2, 40'd0);
        step("R10 invalid ldB", 0, 4'd2, 4'd0, 40'h12_3456_789A);
        step("R10 op12", 1, 4'd12, 4'd0, 40'd0);
        step("R10 op15", 1, 4'd15, 4'd2, 40'd0);
        step("R10 B kept", 1, 4'd5, 4'd0, 40'd0);
        peek("R10 reg2", 4'd2);
        // R6: random instruction stream against the model
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  op;
            logic [39:0] imm;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op = lfsr[3:0];
            imm = {lfsr[7:0], lfsr ^ 32'h5A5A_A5A5};
            step("R6 random", lfsr[9:8] != 2'b00, op, lfsr[13:10], imm);
        end
        for (int r = 0; r < 16; r++) peek("R9 sweep", r[3:0]);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule